// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory and watches each port's enable and word address. When both ports are enabled on the same word, it picks one port to keep the location. It blocks writes from the other port and raises that port's active-low busy flag. The memory array itself lives elsewhere. This block only produces the busy flags and a per-port write-permit signal that the array's write path uses as a gate.

A mode input makes the block either a master or a slave:

- **Master** (mode high): the block makes the decision itself and drives both busy lines.
- **Slave** (mode low): the block does not arbitrate. It takes busy values from a master instance and holds each port's writes back until the imported busy has been steady for a set number of cycles. Several slaves can then follow one master to build a wider word without any slave starting a write during contention.

Arrival order is judged in whole clock cycles. A port counts as having arrived earlier if it was already enabled on the same address in the previous cycle.

Top module: `dp_contention_arb`

## Requirements
- R1: Contention exists only when both port enables are high and all 12 address bits are equal; a difference in any bit, including the top bit, produces no busy and no write blocking.
- R2: In master mode, whenever contention exists exactly one port loses. The two busy outputs are never low at the same time.
- R3: When one port was already enabled on an address in the previous cycle and the other port matches it newly, the earlier port wins and the later port loses.
- R4: When neither port was already on the contended address (both arrive in the same cycle), the left port wins.
- R5: Once a winner is chosen, it keeps the location for as long as the contention continues, even if the loser was the earlier arrival in a later cycle.
- R6: Busy is active low and registered. The losing port's busy goes low one clock edge after contention begins, and both busy outputs are high one edge after contention ends.
- R7: In master mode, a port's write permit equals its write request ANDed with its enable, and is forced low in the same cycle the port is the loser.
- R8: In slave mode, both busy outputs stay high and the block's own decision has no effect on them or on the write permits.
- R9: In slave mode, a port's write permit is high only when all of the following hold:
  - its request and enable are high;
  - its address was unchanged and enabled in the previous cycle;
  - its imported busy is high;
  - that imported value has been unchanged for SETTLE_CYC (default 2) full cycles of such a held access.
- R10: Reset is asynchronous and active low. While it is asserted, both busy outputs are high and the arbitration state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (computes busy), 0 = slave (imports busy) |
| l_en | input | 1 | Left port enable |
| l_addr | input | 12 | Left port word address |
| l_wr_req | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable |
| r_addr | input | 12 | Right port word address |
| r_wr_req | input | 1 | Right port write request |
| busy_in_l_n | input | 1 | Imported left busy, active low (slave mode) |
| busy_in_r_n | input | 1 | Imported right busy, active low (slave mode) |
| busy_l_n | output | 1 | Left busy, active low (driven in master mode) |
| busy_r_n | output | 1 | Right busy, active low (driven in master mode) |
| l_wr_ok | output | 1 | Left write permit to the array |
| r_wr_ok | output | 1 | Right write permit to the array |

## Verification
The assertions check the following on every cycle:
- exactly one loser under contention, and never both busy lines low;
- the one-edge lag of busy behind the loser decision and its release after contention ends;
- the same-cycle tie going to the left port;
- a loser never holding a write permit;
- quiet busy outputs in slave mode;
- a slave permit never coexisting with an active imported busy.

Only the bench's scenarios can show the following:
- which port wins for a given arrival order;
- that a winner persists when arrival history would now favour the other port;
- that a top-bit-only address difference creates no contention;
- the exact cycle count of the slave settle delay after an imported busy pulse.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Full-width word compare between the two ports.
  function automatic logic addr_eq(input logic [11:0] a, input logic [11:0] b);
    return (a == b);
  endfunction

  // New-contention decision from arrival history.
  // Only a right port that was there first beats the left port.
  function automatic owner_e pick_first(input logic l_was_there, input logic r_was_there);
    if (r_was_there && !l_was_there) return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

  // Saturating increment used by the settle counters.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/arb_port_track.sv
module arb_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // Port sat on this same word in the previous cycle.
  assign held = en && en_q && (addr == addr_q);
endmodule

// File: rtl/arb_decide.sv
module arb_decide
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master,
  input  logic   match,
  input  logic   l_held,
  input  logic   r_held,
  output logic   l_lose,
  output logic   r_lose,
  output owner_e owner_q
);
  owner_e win_now;

  always_comb begin
    if (!match)                 win_now = OWN_NONE;
    else if (owner_q != OWN_NONE) win_now = owner_q;
    else                        win_now = pick_first(l_held, r_held);
  end

  assign l_lose = match && (win_now == OWN_RIGHT);
  assign r_lose = match && (win_now == OWN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owner_q <= OWN_NONE;
    else if (!master) owner_q <= OWN_NONE;
    else              owner_q <= win_now;
  end
endmodule

// File: rtl/arb_slave_gate.sv
module arb_slave_gate
  import arb_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic held,
  input  logic busy_in_n,
  output logic ok
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic          imp_q;
  logic [CW-1:0] cnt_q;
  logic          changed;
  logic          settled;

  assign changed = (busy_in_n != imp_q);
  assign settled = (cnt_q == CW'(SETTLE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imp_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      imp_q <= busy_in_n;
      if (!slave || !held || changed) cnt_q <= '0;
      else cnt_q <= CW'(sat_inc(int'(cnt_q), SETTLE_CYC));
    end
  end

  assign ok = slave && held && busy_in_n && !changed && settled;
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import arb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr_req,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr_req,
  input  logic              busy_in_l_n,
  input  logic              busy_in_r_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int NPORT = 2;

  logic              en_v   [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              req_v  [NPORT];
  logic              imp_v  [NPORT];
  logic              held_v [NPORT];
  logic              lose_v [NPORT];
  logic              sok_v  [NPORT];
  logic              busy_q [NPORT];
  logic              wok_v  [NPORT];

  // Named internal events for the checker.
  logic   match;
  logic   l_held, r_held, l_lose, r_lose, owner_none;
  owner_e owner_q;

  assign en_v[0] = l_en;     assign en_v[1] = r_en;
  assign addr_v[0] = l_addr; assign addr_v[1] = r_addr;
  assign req_v[0] = l_wr_req; assign req_v[1] = r_wr_req;
  assign imp_v[0] = busy_in_l_n; assign imp_v[1] = busy_in_r_n;

  assign match = l_en && r_en && addr_eq(12'(l_addr), 12'(r_addr));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    arb_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .addr(addr_v[p]), .held(held_v[p])
    );

    arb_slave_gate #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .slave(!master_mode), .held(held_v[p]),
      .busy_in_n(imp_v[p]), .ok(sok_v[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q[p] <= 1'b1;
      else        busy_q[p] <= !(master_mode && lose_v[p]);
    end

    assign wok_v[p] = master_mode ? (req_v[p] && en_v[p] && !lose_v[p])
                                  : (req_v[p] && en_v[p] && sok_v[p]);
  end

  assign l_held = held_v[0];
  assign r_held = held_v[1];

  arb_decide u_decide (
    .clk(clk), .rst_n(rst_n), .master(master_mode), .match(match),
    .l_held(l_held), .r_held(r_held), .l_lose(l_lose), .r_lose(r_lose),
    .owner_q(owner_q)
  );

  assign lose_v[0] = l_lose;
  assign lose_v[1] = r_lose;
  assign owner_none = (owner_q == OWN_NONE);

  assign busy_l_n = master_mode ? busy_q[0] : 1'b1;
  assign busy_r_n = master_mode ? busy_q[1] : 1'b1;
  assign l_wr_ok  = wok_v[0];
  assign r_wr_ok  = wok_v[1];
endmodule

// File: rtl/dp_contention_arb_chk.sv
module dp_contention_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic match,
  input logic l_held,
  input logic r_held,
  input logic l_lose,
  input logic r_lose,
  input logic owner_none,
  input logic busy_l_n,
  input logic busy_r_n,
  input logic l_wr_ok,
  input logic r_wr_ok,
  input logic busy_in_l_n,
  input logic busy_in_r_n
);
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && match) |-> $countones({l_lose, r_lose}) == 1); // R2
  AST_NOT_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy_l_n && !busy_r_n)); // R2
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && match && owner_none && !l_held && !r_held) |-> !l_lose); // R4
  AST_EARLY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && match && owner_none && r_held && !l_held) |-> l_lose); // R3
  AST_KEEP_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && match && !owner_none && $past(master_mode) && $past(match)) |->
      (l_lose == $past(l_lose))); // R5
  AST_BUSY_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_mode) && master_mode && $past(l_lose)) |-> !busy_l_n); // R6
  AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_mode) && master_mode && !$past(match)) |-> (busy_l_n && busy_r_n)); // R6
  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (l_lose || r_lose)) |-> !(l_lose && l_wr_ok) && !(r_lose && r_wr_ok)); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (busy_l_n && busy_r_n)); // R8
  AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> ((!l_wr_ok || busy_in_l_n) && (!r_wr_ok || busy_in_r_n))); // R9
endmodule

bind dp_contention_arb dp_contention_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .match(match),
  .l_held(l_held), .r_held(r_held), .l_lose(l_lose), .r_lose(r_lose),
  .owner_none(owner_none), .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
  .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok),
  .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n)
);

// File: tb/dp_contention_arb_test.sv
module dp_contention_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b1;
  logic        l_en = 1'b0, r_en = 1'b0, l_wr_req = 1'b0, r_wr_req = 1'b0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic        busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
  logic        busy_l_n, busy_r_n, l_wr_ok, r_wr_ok;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dp_contention_arb uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr_req(l_wr_req),
    .r_en(r_en), .r_addr(r_addr), .r_wr_req(r_wr_req),
    .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  // Vector: mode,len,laddr,lwr,ren,raddr,rwr,bin_l,bin_r | exp lok,rok,busy_l,busy_r
  function automatic logic [34:0] mk(
    input logic m, input logic le, input logic [11:0] la, input logic lw,
    input logic re, input logic [11:0] ra, input logic rw,
    input logic bl, input logic br,
    input logic lok, input logic rok, input logic ebl, input logic ebr);
    return {m, le, la, lw, re, ra, rw, bl, br, lok, rok, ebl, ebr};
  endfunction

  localparam int NV = 23;
  localparam logic [34:0] VEC [NV] = '{
    mk(1,0,12'h000,0,0,12'h000,0,1,1, 0,0,1,1), // 0 idle
    mk(1,1,12'h123,1,0,12'h000,0,1,1, 1,0,1,1), // 1 left alone
    mk(1,1,12'h123,1,1,12'h123,1,1,1, 1,0,1,0), // 2 left earlier
    mk(1,1,12'h123,1,1,12'h123,1,1,1, 1,0,1,0), // 3 keep
    mk(1,1,12'h123,1,1,12'h456,1,1,1, 1,1,1,1), // 4 end
    mk(1,1,12'h456,1,1,12'h456,1,1,1, 0,1,0,1), // 5 right earlier
    mk(1,0,12'h456,1,0,12'h456,1,1,1, 0,0,1,1), // 6 off
    mk(1,1,12'h123,1,1,12'h123,1,1,1, 1,0,1,0), // 7 tie
    mk(1,0,12'h123,0,0,12'h123,0,1,1, 0,0,1,1), // 8 off
    mk(1,1,12'h123,1,1,12'h456,1,1,1, 1,1,1,1), // 9 differ
    mk(1,1,12'hFFF,1,1,12'hFFF,1,1,1, 1,0,1,0), // 10 tie by jump
    mk(1,0,12'hFFF,1,1,12'hFFF,1,1,1, 0,1,1,1), // 11 left leaves
    mk(1,1,12'hFFF,1,1,12'hFFF,1,1,1, 0,1,0,1), // 12 left late
    mk(1,1,12'hFFF,0,1,12'hFFF,0,1,1, 0,0,0,1), // 13 owner kept
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 14 slave new
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 15
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 16
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 1,0,1,1), // 17 settled
    mk(0,1,12'h123,1,0,12'h000,0,0,1, 0,0,1,1), // 18 busy in
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 19 change
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 20
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 0,0,1,1), // 21
    mk(0,1,12'h123,1,0,12'h000,0,1,1, 1,0,1,1)  // 22 settled again
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:          return "R7";
      2, 12:         return "R3";
      3, 13:         return "R5";
      4, 6, 8, 11:   return "R6";
      5:             return "R3";
      7, 10:         return "R4";
      9:             return "R1";
      default:       return (i == 14) ? "R8" : "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [34:0] v);
    {master_mode, l_en, l_addr, l_wr_req, r_en, r_addr, r_wr_req, busy_in_l_n, busy_in_r_n} = v[34:4];
  endtask

  initial begin
    #(8 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state (R10)
    repeat (3) @(negedge clk);
    check("R10", "busy_l_n in reset", busy_l_n, 1'b1);
    check("R10", "busy_r_n in reset", busy_r_n, 1'b1);
    check("R10", "l_wr_ok in reset", l_wr_ok, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #2;
      check(tag_of(i), $sformatf("v%0d l_wr_ok", i), l_wr_ok, VEC[i][3]);
      check(tag_of(i), $sformatf("v%0d r_wr_ok", i), r_wr_ok, VEC[i][2]);
      @(posedge clk);
      #1;
      check(tag_of(i), $sformatf("v%0d busy_l_n", i), busy_l_n, VEC[i][1]);
      check(tag_of(i), $sformatf("v%0d busy_r_n", i), busy_r_n, VEC[i][0]);
    end

    // R1: only the top address bit differs -> no contention
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      apply(mk(1,1,12'h800,1,1,12'h000,1,1,1, 0,0,0,0));
      #2;
      check("R1", "top-bit l_wr_ok", l_wr_ok, 1'b1);
      check("R1", "top-bit r_wr_ok", r_wr_ok, 1'b1);
      @(posedge clk); #1;
      check("R1", "top-bit busy_r_n", busy_r_n, 1'b1);
    end

    // R8: slave mode with a contended address leaves busy high and ignores arbitration
    @(negedge clk);
    apply(mk(0,1,12'h234,0,1,12'h234,0,1,1, 0,0,0,0));
    @(posedge clk); #1;
    @(negedge clk);
    check("R8", "slave busy_l_n", busy_l_n, 1'b1);
    check("R8", "slave busy_r_n", busy_r_n, 1'b1);

    // R10: reset in the middle of contention releases busy at once
    apply(mk(1,1,12'h234,1,1,12'h234,1,1,1, 0,0,0,0));
    @(posedge clk); #1;
    check("R2", "contention right busy", busy_r_n, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "busy_r_n after async reset", busy_r_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    apply(mk(1,0,12'h000,0,0,12'h000,0,1,1, 0,0,0,0));
    @(posedge clk); #1;
    check("R10", "busy_l_n after reset release", busy_l_n, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule